// File: doc/BRIEF.md
# Free-Running Down-Counter with Sign-Bit Interrupt

This block is a free-running binary down-counter for a processor's timer facility. Each tick from the time base lowers the value by one, but only while the time base is globally enabled. Because it steps on the same tick as the time base, the two stay coherent. Software can read the live value at any moment without disturbing it. Software can also overwrite the value with a single-cycle write strobe. With the default width, one full wrap takes 2^32 ticks.

The counter holds no reset logic. Its contents survive every reset, and it keeps stepping and accepting writes while reset is held. Software is expected to load it before relying on it.

An interrupt request is raised whenever the top bit of the counter goes from 0 to 1. This happens either when counting wraps from zero to all ones, or when a software write puts a 1 into a top bit that held 0. The request stays pending until the core takes it and pulses the acknowledge input. Unlike the counter, the pending flag is cleared by reset.

Top module: `decrementer_msb_irq`

## Requirements
- R1: A cycle with `wr_en` high loads `wr_data` into the counter, and the value shows on `rd_data` after that clock edge.
- R2: A cycle with `tb_enable` and `tick_en` both high and no write lowers the counter by exactly one (modulo 2^WIDTH).
- R3: A tick while `tb_enable` is low has no effect on the counter.
- R4: With no write and no enabled tick the counter holds, and any number of reads leaves it unchanged.
- R5: A tick that takes the counter from zero to all ones sets `irq_pending` at that same edge.
- R6: A write sets `irq_pending` when the old top bit is 0 and the written top bit (bit WIDTH-1) is 1. A write whose top bit is 1 while the old top bit is already 1 does not set it.
- R7: When a write and an enabled tick fall in the same cycle, the written value is loaded and the tick is lost. The interrupt decision compares the old value with the written value only.
- R8: Once set, `irq_pending` stays high until a cycle with `irq_ack` high, and reads low after that edge.
- R9: If a new top-bit rise and `irq_ack` fall in the same cycle, `irq_pending` stays high.
- R10: Reset (`rst_n` low) clears `irq_pending` but leaves the counter value as it is. Ticks and writes still act on the counter while reset is held.
- R11: A top-bit fall from 1 to 0, and any change that keeps the top bit at 0, never sets `irq_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, clears the pending flag only |
| tb_enable | input | 1 | Global enable for time-base counting |
| tick_en | input | 1 | One-cycle tick from the time base |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | WIDTH | Value to load |
| rd_data | output | WIDTH | Live counter value |
| irq_ack | input | 1 | Interrupt taken, clears the pending flag |
| irq_pending | output | 1 | Interrupt request |

## Verification
Counting is exercised with runs of enabled ticks and with ticks while the global enable is low, which separates real decrements from ignored strobes. The interrupt is driven in four ways: wrapping from zero, a write that sets the top bit from 0, a write that keeps the top bit at 1, and a count that clears the top bit. Together these tell a true 0-to-1 detector apart from a level check or a plain any-change check. Write-and-tick collisions are placed where the tick alone would or would not wrap, which shows that the write value decides the outcome. Acknowledge is applied both alone and together with a fresh rise, and reset is applied while pending is set and while ticks arrive.

// File: rtl/dec_pkg.sv
package dec_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'b00,
      OP_STEP = 2'b01,
      OP_LOAD = 2'b10
   } dec_op_e;

endpackage

// File: rtl/dec_op_select.sv
module dec_op_select
   import dec_pkg::*;
(
   input  logic    wr_en,
   input  logic    tb_enable,
   input  logic    tick_en,
   output dec_op_e op
);

   always_comb begin
      if (wr_en)
         op = OP_LOAD;
      else if (tb_enable && tick_en)
         op = OP_STEP;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/dec_count_core.sv
module dec_count_core
   import dec_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  dec_op_e          op,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] cnt_q,
   output logic [WIDTH-1:0] cnt_d
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_comb begin
      unique case (op)
         OP_LOAD: cnt_d = load_val;
         OP_STEP: cnt_d = cnt_q - ONE;
         default: cnt_d = cnt_q;
      endcase
   end

   // no reset on purpose: the value survives and keeps running through reset
   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

endmodule

// File: rtl/dec_msb_rise.sv
module dec_msb_rise (
   input  logic cur_msb,
   input  logic nxt_msb,
   output logic rise
);

   assign rise = nxt_msb & ~cur_msb;

endmodule

// File: rtl/dec_irq_flag.sv
module dec_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic pending
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending <= 1'b0;
      else if (set)
         pending <= 1'b1;
      else if (ack)
         pending <= 1'b0;
   end

endmodule

// File: rtl/decrementer_msb_irq.sv
module decrementer_msb_irq
   import dec_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_enable,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   input  logic             irq_ack,
   output logic             irq_pending
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("decrementer_msb_irq: WIDTH must be at least 2");
      end
   endgenerate

   dec_op_e          op;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;
   logic             msb_rise;

   dec_op_select u_sel (
      .wr_en     (wr_en),
      .tb_enable (tb_enable),
      .tick_en   (tick_en),
      .op        (op)
   );

   dec_count_core #(.WIDTH(WIDTH)) u_core (
      .clk      (clk),
      .op       (op),
      .load_val (wr_data),
      .cnt_q    (cnt_q),
      .cnt_d    (cnt_d)
   );

   dec_msb_rise u_rise (
      .cur_msb (cnt_q[MSB]),
      .nxt_msb (cnt_d[MSB]),
      .rise    (msb_rise)
   );

   dec_irq_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (msb_rise),
      .ack     (irq_ack),
      .pending (irq_pending)
   );

   assign rd_data = cnt_q;

endmodule

// File: rtl/dec_msb_irq_checker.sv
module dec_msb_irq_checker #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tb_enable,
   input logic             tick_en,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] rd_data,
   input logic             irq_ack,
   input logic             irq_pending
);

   localparam int MSB = WIDTH - 1;

   // counter content is only meaningful once something has been written
   logic known;
   always_ff @(posedge clk) begin
      if (wr_en)
         known <= 1'b1;
      else if (known !== 1'b1)
         known <= 1'b0;
   end

   assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(wr_data));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (known && !wr_en && tb_enable && tick_en)
         |=> rd_data == $past(rd_data) - WIDTH'(1));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (known && !wr_en && !(tb_enable && tick_en)) |=> $stable(rd_data));

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (known && !wr_en && tb_enable && tick_en && rd_data == '0) |=> irq_pending);

   assert_wrset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (known && wr_en && wr_data[MSB] && !rd_data[MSB]) |=> irq_pending);

   assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pending && !irq_ack) |=> irq_pending);

   assert_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (known && !irq_pending) |=> (!irq_pending || $rose(rd_data[MSB])));

   assert_clear_R10: assert property (@(posedge clk)
      !rst_n |-> !irq_pending);

endmodule

bind decrementer_msb_irq dec_msb_irq_checker #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tb_enable   (tb_enable),
   .tick_en     (tick_en),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .irq_ack     (irq_ack),
   .irq_pending (irq_pending)
);

// File: tb/decrementer_msb_irq_test.sv
`timescale 1ns/1ps
module decrementer_msb_irq_test;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tb_enable = 1'b0;
   logic         tick_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         irq_ack = 1'b0;
   logic         irq_pending;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   decrementer_msb_irq #(.WIDTH(W)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tb_enable   (tb_enable),
      .tick_en     (tick_en),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .irq_ack     (irq_ack),
      .irq_pending (irq_pending)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one cycle's inputs at the falling edge, then sample just after the rising edge
   task automatic cyc(input logic w, input logic [W-1:0] d, input logic en,
                      input logic tk, input logic ak);
      @(negedge clk);
      wr_en = w; wr_data = d; tb_enable = en; tick_en = tk; irq_ack = ak;
      @(posedge clk);
      #1;
      wr_en = 1'b0; tick_en = 1'b0; irq_ack = 1'b0;
   endtask

   task automatic t_reset;
      chk("R10 pending low in reset", W'(irq_pending), '0);
      cyc(1'b1, 32'h0000_0100, 1'b0, 1'b0, 1'b0);
      chk("R10 write during reset", rd_data, 32'h0000_0100);
      cyc(1'b0, '0, 1'b1, 1'b1, 1'b0);
      chk("R10 counts during reset", rd_data, 32'h0000_00FF);
      @(negedge clk); rst_n = 1'b1;
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b0);
      chk("R10 value kept over reset", rd_data, 32'h0000_00FF);
   endtask

   task automatic t_count;
      cyc(1'b1, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
      chk("R1 load", rd_data, 32'h1234_5678);
      chk("R11 no irq msb stays 0", W'(irq_pending), '0);
      for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, 1'b1, 1'b0);
      chk("R2 three steps", rd_data, 32'h1234_5675);
      cyc(1'b0, '0, 1'b0, 1'b1, 1'b0);
      cyc(1'b0, '0, 1'b0, 1'b1, 1'b0);
      chk("R3 tick while disabled", rd_data, 32'h1234_5675);
      for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
      chk("R4 hold without tick", rd_data, 32'h1234_5675);
      chk("R4 repeated read", rd_data, 32'h1234_5675);
   endtask

   task automatic t_wrap;
      cyc(1'b1, 32'h0000_0001, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, '0, 1'b1, 1'b1, 1'b0);
      chk("R11 reach zero", W'(irq_pending), '0);
      cyc(1'b0, '0, 1'b1, 1'b1, 1'b0);
      chk("R5 wrap value", rd_data, 32'hFFFF_FFFF);
      chk("R5 wrap irq", W'(irq_pending), 1);
      for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
      chk("R8 held until ack", W'(irq_pending), 1);
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b1);
      chk("R8 cleared by ack", W'(irq_pending), '0);
   endtask

   task automatic t_msb;
      cyc(1'b1, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
      chk("R6 write msb1 over msb1", W'(irq_pending), '0);
      cyc(1'b0, '0, 1'b1, 1'b1, 1'b0);
      chk("R11 msb fall value", rd_data, 32'h7FFF_FFFF);
      chk("R11 msb fall no irq", W'(irq_pending), '0);
      cyc(1'b1, 32'h8000_0001, 1'b1, 1'b0, 1'b0);
      chk("R6 write sets msb", W'(irq_pending), 1);
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_collide;
      cyc(1'b1, 32'h0000_0005, 1'b1, 1'b0, 1'b0);
      cyc(1'b1, 32'h0000_0009, 1'b1, 1'b1, 1'b0);
      chk("R7 write beats tick", rd_data, 32'h0000_0009);
      cyc(1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
      cyc(1'b1, 32'h7000_0000, 1'b1, 1'b1, 1'b0);
      chk("R7 no wrap value", rd_data, 32'h7000_0000);
      chk("R7 no wrap irq", W'(irq_pending), '0);
      cyc(1'b1, 32'h0000_0010, 1'b1, 1'b0, 1'b0);
      cyc(1'b1, 32'h8000_0000, 1'b1, 1'b1, 1'b0);
      chk("R7 write msb with tick", W'(irq_pending), 1);
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_set_ack;
      cyc(1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
      cyc(1'b1, 32'hC000_0000, 1'b1, 1'b0, 1'b0);
      cyc(1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
      chk("R9 pending before", W'(irq_pending), 1);
      cyc(1'b0, '0, 1'b1, 1'b1, 1'b1);
      chk("R9 set beats ack", W'(irq_pending), 1);
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b1);
      chk("R9 later ack clears", W'(irq_pending), '0);
   endtask

   task automatic t_reset_pending;
      cyc(1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, '0, 1'b1, 1'b1, 1'b0);
      chk("R10 pending before reset", W'(irq_pending), 1);
      @(negedge clk); rst_n = 1'b0;
      #1;
      chk("R10 reset clears pending", W'(irq_pending), '0);
      chk("R10 reset keeps value", rd_data, 32'hFFFF_FFFF);
      @(negedge clk); rst_n = 1'b1;
      cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      t_reset();
      t_count();
      t_wrap();
      t_msb();
      t_collide();
      t_set_ack();
      t_reset_pending();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule